// File: doc/BRIEF.md
# Three-Source Interrupt Control Register

This block is a single 32-bit interrupt control register that serves three interrupt sources: an error source, a vertical-blank source and a packet-buffer-done source. Each source owns a 4-bit slice of the register, holding an enable flag and a pending flag. Hardware request pulses latch into the pending flags. A single interrupt line is raised while any enabled source has a request pending.

Software updates the register with whole-word writes. Each slice has a write-gate bit in the written data, and only slices whose gate bit is 1 take the written enable and pending values. A driver can therefore acknowledge or reconfigure one source in one write, without first reading the register, and without disturbing the other two sources. The gate bits only qualify the write. They are never stored.

Top module: `tri_irq_reg`

## Requirements
- R1: After a synchronous reset, `rd_data` is 0 and `irq` is 0.
- R2: Source slices begin at bit 0 (error, `src_req[0]`), bit 8 (vertical blank, `src_req[1]`) and bit 16 (packet done, `src_req[2]`). Within a slice, offset 0 holds the enable and offset 1 holds the pending flag. Every other bit of `rd_data` reads 0, including the write-gate bits at offset 2 and the unused top bits at offset 3.
- R3: When `wr_en` is 1 and a slice's write-gate bit (slice offset 2) is 1 in `wr_data`, that slice's enable and pending flags take `wr_data` slice offsets 0 and 1 on the next clock edge.
- R4: A write whose data has a slice's write-gate bit at 0 leaves that slice's enable and pending flags unchanged.
- R5: A 1 on `src_req[i]` sets slice i's pending flag on the next edge, whether the slice is enabled or not.
- R6: If a gated write clears a pending flag in the same cycle that the matching `src_req` bit is 1, the pending flag ends up set.
- R7: `irq` is registered. In each cycle it equals the OR, over the three slices, of enable AND pending as they stood in the previous cycle.
- R8: A gated write with pending offset 1 at 1 sets the pending flag, and this raises `irq` when the slice is enabled.
- R9: With no request and no gated write, enable and pending flags hold their values across cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data, including the per-slice write-gate bits |
| src_req | input | 3 | Request pulses: bit 0 error, bit 1 vertical blank, bit 2 packet done |
| rd_data | output | 32 | Current register contents |
| irq | output | 1 | Interrupt line |

## Verification
The bench targets a request that arrives in the same cycle as a clearing write. A design that lets the write win here loses an interrupt, and the pending flag reads 0. It sends writes that gate only one slice while the data bits for the other slices are set. A design that ignores the gate would change neighbouring enables. It writes all ones to show that the gate and top bits read back 0, and that a design storing them would expose stray bits. It also checks that `irq` appears exactly one cycle after a slice becomes live. This catches both a combinational interrupt path and an extra pipeline stage. A long pseudo-random phase then compares every cycle against a behavioural model.

// File: rtl/tri_irq_pkg.sv
package tri_irq_pkg;
    localparam int DATA_W       = 32;
    localparam int NUM_SRC      = 3;
    localparam int FIELD_STRIDE = 8;
    localparam int BIT_EN       = 0;
    localparam int BIT_PEND     = 1;
    localparam int BIT_GATE     = 2;

    typedef struct packed {
        logic en;
        logic pend;
    } src_state_t;

    typedef struct packed {
        logic load;
        logic en;
        logic pend;
    } src_cmd_t;

    function automatic int slice_base(input int idx);
        return idx * FIELD_STRIDE;
    endfunction
endpackage

// File: rtl/irq_slice.sv
module irq_slice
    import tri_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  src_cmd_t   cmd,
    input  logic       req,
    output src_state_t state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (cmd.load) begin
            state.en   <= cmd.en;
            state.pend <= cmd.pend | req;
        end else begin
            state.pend <= state.pend | req;
        end
    end
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] en_vec,
    input  logic [N-1:0] pend_vec,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(en_vec & pend_vec);
    end
endmodule

// File: rtl/tri_irq_reg.sv
module tri_irq_reg
    import tri_irq_pkg::*;
#(
    parameter int NUM_SRC_P    = tri_irq_pkg::NUM_SRC,
    parameter int FIELD_STRIDE_P = tri_irq_pkg::FIELD_STRIDE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [NUM_SRC_P-1:0] src_req,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 irq
);
    localparam int SPAN = NUM_SRC_P * FIELD_STRIDE_P;

    src_state_t           st [NUM_SRC_P];
    logic [NUM_SRC_P-1:0] en_vec;
    logic [NUM_SRC_P-1:0] pend_vec;

    for (genvar g = 0; g < NUM_SRC_P; g++) begin : g_src
        localparam int B = g * FIELD_STRIDE_P;
        src_cmd_t cmd;
        assign cmd.load = wr_en & wr_data[B + BIT_GATE];
        assign cmd.en   = wr_data[B + BIT_EN];
        assign cmd.pend = wr_data[B + BIT_PEND];

        irq_slice u_slice (
            .clk   (clk),
            .rst   (rst),
            .cmd   (cmd),
            .req   (src_req[g]),
            .state (st[g])
        );

        assign en_vec[g]   = st[g].en;
        assign pend_vec[g] = st[g].pend;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_SRC_P; i++) begin
            rd_data[i * FIELD_STRIDE_P + BIT_EN]   = en_vec[i];
            rd_data[i * FIELD_STRIDE_P + BIT_PEND] = pend_vec[i];
        end
    end

    irq_merge #(.N(NUM_SRC_P)) u_merge (
        .clk      (clk),
        .rst      (rst),
        .en_vec   (en_vec),
        .pend_vec (pend_vec),
        .irq      (irq)
    );

    if (SPAN > DATA_W) begin : g_bad_cfg
        initial $error("tri_irq_reg: slices exceed register width");
    end
endmodule

// File: rtl/tri_irq_chk.sv
module tri_irq_chk
    import tri_irq_pkg::*;
#(
    parameter int NUM_SRC_P      = tri_irq_pkg::NUM_SRC,
    parameter int FIELD_STRIDE_P = tri_irq_pkg::FIELD_STRIDE
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [DATA_W-1:0]    wr_data,
    input logic [NUM_SRC_P-1:0] src_req,
    input logic [DATA_W-1:0]    rd_data,
    input logic                 irq
);
    function automatic logic [DATA_W-1:0] live_mask();
        logic [DATA_W-1:0] m = '0;
        for (int i = 0; i < NUM_SRC_P; i++) begin
            m[i * FIELD_STRIDE_P + BIT_EN]   = 1'b1;
            m[i * FIELD_STRIDE_P + BIT_PEND] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] LIVE = live_mask();

    logic any_live;
    always_comb begin
        any_live = 1'b0;
        for (int i = 0; i < NUM_SRC_P; i++)
            any_live = any_live | (rd_data[i * FIELD_STRIDE_P + BIT_EN] &
                                   rd_data[i * FIELD_STRIDE_P + BIT_PEND]);
    end

    assert_dead_bits_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~LIVE) == '0);

    assert_irq_latency_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq == $past(any_live));

    for (genvar g = 0; g < NUM_SRC_P; g++) begin : g_chk
        localparam int B = g * FIELD_STRIDE_P;

        assert_req_sets_R5: assert property (@(posedge clk) disable iff (rst)
            src_req[g] |=> rd_data[B + BIT_PEND]);

        assert_gated_load_R3: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_data[B + BIT_GATE] && !src_req[g]) |=>
            (rd_data[B + BIT_EN] == $past(wr_data[B + BIT_EN]) &&
             rd_data[B + BIT_PEND] == $past(wr_data[B + BIT_PEND])));

        assert_ungated_hold_R4: assert property (@(posedge clk) disable iff (rst)
            (!(wr_en && wr_data[B + BIT_GATE]) && !src_req[g]) |=>
            $stable(rd_data[B +: 2]));
    end
endmodule

bind tri_irq_reg tri_irq_chk #(
    .NUM_SRC_P      (NUM_SRC_P),
    .FIELD_STRIDE_P (FIELD_STRIDE_P)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .src_req (src_req),
    .rd_data (rd_data),
    .irq     (irq)
);

// File: tb/test_tri_irq_reg.sv
module test_tri_irq_reg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [2:0]  src_req = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    bit m_en [3];
    bit m_pend [3];
    bit m_irq;

    always #10 clk = ~clk;

    tri_irq_reg i_tri_irq_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .src_req (src_req),
        .rd_data (rd_data),
        .irq     (irq)
    );

    function automatic logic [31:0] model_word();
        logic [31:0] w = '0;
        for (int i = 0; i < 3; i++) begin
            w[i * 8]     = m_en[i];
            w[i * 8 + 1] = m_pend[i];
        end
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, rd_data, model_word());
        check("R7", {31'd0, irq}, {31'd0, m_irq});
    endtask

    // Called at a falling edge; drives, clocks, updates the model, compares.
    task automatic step(input logic w, input logic [31:0] d, input logic [2:0] r,
                        input string tag);
        bit nirq;
        wr_en = w; wr_data = d; src_req = r;
        @(posedge clk);
        nirq = 0;
        for (int i = 0; i < 3; i++) if (m_en[i] && m_pend[i]) nirq = 1;
        for (int i = 0; i < 3; i++) begin
            if (w && d[i * 8 + 2]) begin
                m_en[i]   = d[i * 8];
                m_pend[i] = d[i * 8 + 1] || r[i];
            end else begin
                m_pend[i] = m_pend[i] || r[i];
            end
        end
        m_irq = nirq;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr = 32'hACE1_2B3D;
        for (int i = 0; i < 3; i++) begin m_en[i] = 0; m_pend[i] = 0; end
        m_irq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare("R1");                                  // R1 reset state

        step(0, '0, 3'b001, "R5");                      // R5 request while disabled
        step(0, '0, 3'b000, "R9");                      // R9 hold, irq stays 0
        step(1, 32'h0000_0005, 3'b000, "R3");           // R3 enable error slice
        step(0, '0, 3'b000, "R7");                      // R7 irq one cycle later
        step(1, 32'h0003_0403, 3'b000, "R4");           // R4 only vblank gated
        step(1, 32'h0000_0004, 3'b001, "R6");           // R6 request beats clear
        step(1, 32'h0000_0004, 3'b000, "R3");           // R3 clear error pending
        step(1, 32'h0006_0000, 3'b000, "R8");           // R8 software raise pkt
        step(0, '0, 3'b000, "R8");
        step(1, 32'hFFFF_FFFF, 3'b000, "R2");           // R2 gate/top bits read 0
        step(1, 32'h0004_0404, 3'b000, "R3");           // R3 clear everything
        step(0, '0, 3'b110, "R5");                      // R5 two disabled sources
        step(1, 32'h0000_0006, 3'b010, "R4");           // R4 error gated, vblank req
        step(0, '0, 3'b000, "R9");

        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[3] & lfsr[9], lfsr ^ {lfsr[15:0], lfsr[31:16]},
                 (lfsr[12:10] & lfsr[27:25]), "R9");    // mixed traffic vs model
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule